// File: doc/BRIEF.md
# Storage Host Port Register Bank

This block is the memory-mapped control and status front end of a multi-port serial storage host controller. Software reaches it through 32-bit reads and writes on a simple valid/write bus. A short global area sits at the bottom of the address space. Above a fixed base address, each port has its own 128-byte window. The block holds the per-port interrupt status and enable registers, the command-issue and active-tag registers, and the command register. The command register carries the start and receive-enable requests for the two per-port engines.

Engines elsewhere in the controller take their enable requests from this block. They report that they are running through acknowledge inputs, and those inputs show up as read-only bits. Hardware events set per-port interrupt status bits. Any port with an enabled, pending status rolls up into a sticky global status vector. That vector drives a single interrupt line, gated by a global interrupt-enable bit.

Top module: `hba_regbank`

## Requirements
- R1: After reset the port registers read as follows: interrupt status 0, interrupt enable 0, command 0x00000006 (bit 1 spin-up and bit 2 power-on set), task-file 0x7F, signature 0xFFFFFFFF, command-issue 0 and active 0. The global control register reads 0x80000000 and the global status register reads 0.
- R2: The capability register (offset 0x00) reads NPORTS-1 in its low bits. The implemented-ports register (0x0C) reads (1<<NPORTS)-1. The version register (0x10) reads 0x00010000.
- R3: A write to global control (0x04) keeps only data bits [1:0]. Bit 31 always reads 1, and bits [30:2] read 0.
- R4: A port interrupt status register (port offset 0x10) is set by `port_evt` and cleared by writing 1s. When an event and a clear hit the same bit in the same cycle, the event wins.
- R5: A write to a port interrupt enable register (port offset 0x14) stores the data ANDed with 0xFDC000FF.
- R6: Writes to the active register (port offset 0x34) and the command-issue register (port offset 0x38) OR the data into the current contents. Writing 0 changes nothing.
- R7: When a command-register write (port offset 0x18) takes bit 0 from 1 to 0, the active and command-issue registers of that port both become 0. A write that leaves bit 0 at 0 does not touch them.
- R8: Command bits 15 and 14 read as `list_ack` and `fis_ack` of that port, and writes do not affect them. `list_en` and `fis_en` follow command bits 0 and 4.
- R9: Global status bit i (0x08) is set one cycle after port i has status AND enable nonzero. Writing it with 1 clears the bit, but only once the port is no longer pending. The bit stays set after the port condition goes away.
- R10: `irq` is high exactly when the global status is nonzero and global control bit 1 is set.
- R11: Reads from an unimplemented port, an unused port offset or an unused global offset return 0. Writes to them, and writes to read-only registers, change nothing.
- R12: The port index is (address − 0x100) >> 7. A write reaches only the addressed port.
- R13: Read data appears on `bus_rdata` with `bus_rvalid` one cycle after the read request, and it reflects the state before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| port_evt | input | NPORTS*32 | Per-port interrupt status set pulses, port i in bits [32i+31:32i] |
| list_ack | input | NPORTS | Command-list engine running, per port |
| fis_ack | input | NPORTS | Receive engine running, per port |
| list_en | output | NPORTS | Command-list engine enable request (command bit 0) |
| fis_en | output | NPORTS | Receive engine enable request (command bit 4) |
| irq | output | 1 | Aggregated interrupt |

## Verification
A corrupted port status or enable register shows up first in the global status vector, one cycle after the corrupting edge. With the global enable set, it shows up on `irq` in the same cycle. A lost or spurious roll-up shows directly as `irq` held at the wrong level across a write-1-to-clear. A wrong port index or offset decode lands a write in a neighbour's register, and the next read of that neighbour shows it, so the bench follows every write to one port with reads of the others. Errors in the stop-side clearing of the command-issue and active registers are visible on the read immediately after the command write.

// File: rtl/hba_regs_pkg.sv
package hba_regs_pkg;

    localparam int          DW          = 32;
    localparam int          PORT_BASE   = 32'h100;
    localparam int          PORT_SHIFT  = 7;

    // global area offsets
    localparam logic [7:0]  G_CAP_OFF   = 8'h00;
    localparam logic [7:0]  G_CTL_OFF   = 8'h04;
    localparam logic [7:0]  G_IS_OFF    = 8'h08;
    localparam logic [7:0]  G_IMPL_OFF  = 8'h0C;
    localparam logic [7:0]  G_VER_OFF   = 8'h10;

    // per-port offsets
    localparam logic [6:0]  P_IS_OFF    = 7'h10;
    localparam logic [6:0]  P_IE_OFF    = 7'h14;
    localparam logic [6:0]  P_CMD_OFF   = 7'h18;
    localparam logic [6:0]  P_TFD_OFF   = 7'h20;
    localparam logic [6:0]  P_SIG_OFF   = 7'h24;
    localparam logic [6:0]  P_ACT_OFF   = 7'h34;
    localparam logic [6:0]  P_CI_OFF    = 7'h38;

    localparam logic [DW-1:0] IE_WMASK    = 32'hFDC0_00FF;
    localparam logic [DW-1:0] CMD_RO_MASK = 32'h0000_C000;
    localparam logic [DW-1:0] CMD_RESET   = 32'h0000_0006;
    localparam logic [DW-1:0] TFD_RESET   = 32'h0000_007F;
    localparam logic [DW-1:0] SIG_RESET   = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] VERSION_VAL = 32'h0001_0000;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_RXEN_BIT  = 4;
    localparam int CMD_RXRUN_BIT = 14;
    localparam int CMD_LRUN_BIT  = 15;
    localparam int CTL_IEN_BIT   = 1;
    localparam int CTL_AE_BIT    = 31;

    typedef enum logic [2:0] {
        PR_NONE, PR_IS, PR_IE, PR_CMD, PR_TFD, PR_SIG, PR_ACT, PR_CI
    } port_reg_e;

    typedef enum logic [2:0] {
        GR_NONE, GR_CAP, GR_CTL, GR_IS, GR_IMPL, GR_VER
    } glob_reg_e;

    typedef struct packed {
        logic            wr;
        port_reg_e       sel_reg;
        logic [DW-1:0]   data;
    } port_acc_t;

    function automatic port_reg_e port_reg_decode(input logic [6:0] off);
        case (off)
            P_IS_OFF:  return PR_IS;
            P_IE_OFF:  return PR_IE;
            P_CMD_OFF: return PR_CMD;
            P_TFD_OFF: return PR_TFD;
            P_SIG_OFF: return PR_SIG;
            P_ACT_OFF: return PR_ACT;
            P_CI_OFF:  return PR_CI;
            default:   return PR_NONE;
        endcase
    endfunction

    function automatic glob_reg_e glob_reg_decode(input logic [7:0] off);
        case (off)
            G_CAP_OFF:  return GR_CAP;
            G_CTL_OFF:  return GR_CTL;
            G_IS_OFF:   return GR_IS;
            G_IMPL_OFF: return GR_IMPL;
            G_VER_OFF:  return GR_VER;
            default:    return GR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hba_port_bank.sv
module hba_port_bank
    import hba_regs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  port_acc_t       acc,
    input  logic [DW-1:0]   evt,
    input  logic            list_ack,
    input  logic            fis_ack,
    output logic [DW-1:0]   rdata,
    output logic            pending,
    output logic            list_en,
    output logic            fis_en,
    output logic [DW-1:0]   is_o,
    output logic [DW-1:0]   ci_o,
    output logic [DW-1:0]   act_o
);

    logic [DW-1:0] is_q, ie_q, cmd_q, ci_q, act_q;
    logic [DW-1:0] is_clr;
    logic          stop_req;

    always_comb begin
        is_clr   = (acc.wr && acc.sel_reg == PR_IS) ? acc.data : '0;
        stop_req = acc.wr && acc.sel_reg == PR_CMD &&
                   cmd_q[CMD_START_BIT] && !acc.data[CMD_START_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            is_q  <= '0;
            ie_q  <= '0;
            cmd_q <= CMD_RESET;
            ci_q  <= '0;
            act_q <= '0;
        end else begin
            is_q <= (is_q & ~is_clr) | evt;
            if (acc.wr && acc.sel_reg == PR_IE)
                ie_q <= acc.data & IE_WMASK;
            if (acc.wr && acc.sel_reg == PR_CMD)
                cmd_q <= acc.data & ~CMD_RO_MASK;
            if (stop_req) begin
                ci_q  <= '0;
                act_q <= '0;
            end else begin
                if (acc.wr && acc.sel_reg == PR_CI)
                    ci_q <= ci_q | acc.data;
                if (acc.wr && acc.sel_reg == PR_ACT)
                    act_q <= act_q | acc.data;
            end
        end
    end

    logic [DW-1:0] cmd_rd;
    always_comb begin
        cmd_rd = cmd_q;
        cmd_rd[CMD_LRUN_BIT]  = list_ack;
        cmd_rd[CMD_RXRUN_BIT] = fis_ack;
        case (acc.sel_reg)
            PR_IS:   rdata = is_q;
            PR_IE:   rdata = ie_q;
            PR_CMD:  rdata = cmd_rd;
            PR_TFD:  rdata = TFD_RESET;
            PR_SIG:  rdata = SIG_RESET;
            PR_ACT:  rdata = act_q;
            PR_CI:   rdata = ci_q;
            default: rdata = '0;
        endcase
    end

    assign pending = |(is_q & ie_q);
    assign list_en = cmd_q[CMD_START_BIT];
    assign fis_en  = cmd_q[CMD_RXEN_BIT];
    assign is_o    = is_q;
    assign ci_o    = ci_q;
    assign act_o   = act_q;

endmodule

// File: rtl/hba_glob_ctl.sv
module hba_glob_ctl
    import hba_regs_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  glob_reg_e         sel_reg,
    input  logic [DW-1:0]     wdata,
    input  logic [NPORTS-1:0] pend,
    output logic [DW-1:0]     rdata,
    output logic [NPORTS-1:0] gis_q,
    output logic              irq
);

    logic [1:0]        ctl_q;
    logic [NPORTS-1:0] gis_clr;

    assign gis_clr = (wr && sel_reg == GR_IS) ? wdata[NPORTS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            gis_q <= '0;
        end else begin
            if (wr && sel_reg == GR_CTL)
                ctl_q <= wdata[1:0];
            gis_q <= (gis_q & ~gis_clr) | pend;
        end
    end

    logic [DW-1:0] ctl_rd;
    always_comb begin
        ctl_rd             = '0;
        ctl_rd[1:0]        = ctl_q;
        ctl_rd[CTL_AE_BIT] = 1'b1;
        case (sel_reg)
            GR_CAP:  rdata = DW'(NPORTS - 1);
            GR_CTL:  rdata = ctl_rd;
            GR_IS:   rdata = DW'(gis_q);
            GR_IMPL: rdata = DW'((64'd1 << NPORTS) - 64'd1);
            GR_VER:  rdata = VERSION_VAL;
            default: rdata = '0;
        endcase
    end

    assign irq = (|gis_q) && ctl_q[CTL_IEN_BIT];

endmodule

// File: rtl/hba_regbank.sv
module hba_regbank
    import hba_regs_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NPORTS*DW-1:0] port_evt,
    input  logic [NPORTS-1:0]    list_ack,
    input  logic [NPORTS-1:0]    fis_ack,
    output logic [NPORTS-1:0]    list_en,
    output logic [NPORTS-1:0]    fis_en,
    output logic                 irq
);

    localparam int PIDX_W = ADDR_W - PORT_SHIFT;

    logic [ADDR_W-1:0] rel;
    logic [PIDX_W-1:0] pidx;
    logic              glob_hit, port_hit, do_wr, do_rd;
    port_reg_e         preg;
    glob_reg_e         greg;

    always_comb begin
        rel      = bus_addr - ADDR_W'(PORT_BASE);
        pidx     = rel[ADDR_W-1:PORT_SHIFT];
        glob_hit = bus_addr < ADDR_W'(PORT_BASE);
        port_hit = !glob_hit && (int'(pidx) < NPORTS);
        preg     = port_reg_decode(rel[PORT_SHIFT-1:0]);
        greg     = glob_hit ? glob_reg_decode(bus_addr[7:0]) : GR_NONE;
        do_wr    = bus_valid && bus_write;
        do_rd    = bus_valid && !bus_write;
    end

    logic [NPORTS-1:0]    pend;
    logic [NPORTS-1:0]    gis_q;
    logic [NPORTS*DW-1:0] is_flat, ci_flat, act_flat;
    logic [DW-1:0]        port_rd [NPORTS];
    logic [DW-1:0]        glob_rd;

    hba_glob_ctl #(.NPORTS(NPORTS)) u_glob (
        .clk     (clk),
        .rst     (rst),
        .wr      (do_wr && glob_hit),
        .sel_reg (greg),
        .wdata   (bus_wdata),
        .pend    (pend),
        .rdata   (glob_rd),
        .gis_q   (gis_q),
        .irq     (irq)
    );

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        port_acc_t acc;
        assign acc.wr      = do_wr && port_hit && (pidx == PIDX_W'(i));
        assign acc.sel_reg = preg;
        assign acc.data    = bus_wdata;

        hba_port_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .acc      (acc),
            .evt      (port_evt[i*DW +: DW]),
            .list_ack (list_ack[i]),
            .fis_ack  (fis_ack[i]),
            .rdata    (port_rd[i]),
            .pending  (pend[i]),
            .list_en  (list_en[i]),
            .fis_en   (fis_en[i]),
            .is_o     (is_flat[i*DW +: DW]),
            .ci_o     (ci_flat[i*DW +: DW]),
            .act_o    (act_flat[i*DW +: DW])
        );
    end

    logic [DW-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (glob_hit)
            rd_mux = glob_rd;
        else if (port_hit)
            for (int i = 0; i < NPORTS; i++)
                if (pidx == PIDX_W'(i))
                    rd_mux = port_rd[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= do_rd;
            if (do_rd)
                bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/hba_regbank_chk.sv
module hba_regbank_chk
    import hba_regs_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DW-1:0]        bus_rdata,
    input logic                 bus_rvalid,
    input logic [NPORTS*DW-1:0] port_evt,
    input logic [NPORTS-1:0]    list_en,
    input logic [NPORTS*DW-1:0] is_flat,
    input logic [NPORTS*DW-1:0] ci_flat,
    input logic [NPORTS*DW-1:0] act_flat,
    input logic [NPORTS-1:0]    gis_q,
    input logic [NPORTS-1:0]    pend
);

    logic rd_unimpl_port, rd_ctl;
    always_comb begin
        rd_unimpl_port = bus_valid && !bus_write &&
                         (int'(bus_addr) >= PORT_BASE) &&
                         (((int'(bus_addr) - PORT_BASE) >> PORT_SHIFT) >= NPORTS);
        rd_ctl = bus_valid && !bus_write && (bus_addr == ADDR_W'(G_CTL_OFF));
    end

    // R4
    evt_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (|port_evt) |=> ((is_flat & $past(port_evt)) == $past(port_evt)));

    // R9
    gis_source_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> ((gis_q & ~$past(gis_q) & ~$past(pend)) == '0));

    // R9
    gis_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> ((gis_q & $past(pend)) == $past(pend)));

    // R11
    unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_unimpl_port |=> (bus_rvalid && bus_rdata == '0));

    // R3
    ctl_read_form_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ctl |=> (bus_rdata[CTL_AE_BIT] && bus_rdata[30:2] == '0));

    for (genvar i = 0; i < NPORTS; i++) begin : g_chk
        // R7
        stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(list_en[i]) |-> (ci_flat[i*DW +: DW] == '0 && act_flat[i*DW +: DW] == '0));
    end

endmodule

bind hba_regbank hba_regbank_chk #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .port_evt   (port_evt),
    .list_en    (list_en),
    .is_flat    (is_flat),
    .ci_flat    (ci_flat),
    .act_flat   (act_flat),
    .gis_q      (gis_q),
    .pend       (pend)
);

// File: tb/hba_regbank_tb.sv
module hba_regbank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             bus_rvalid;
    logic [NP*32-1:0] port_evt = '0;
    logic [NP-1:0]    list_ack = '0;
    logic [NP-1:0]    fis_ack = '0;
    logic [NP-1:0]    list_en;
    logic [NP-1:0]    fis_en;
    logic             irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    hba_regbank #(.NPORTS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .port_evt(port_evt), .list_ack(list_ack), .fis_ack(fis_ack),
        .list_en(list_en), .fis_en(fis_en), .irq(irq)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [AW-1:0] pa(input int port, input int off);
        return AW'(32'h100 + port * 128 + off);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_fail++;
                $display("FAIL R13: actual unexpected read data %h expected none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] expv, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(expv); tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic evt(input int port, input logic [31:0] bits);
        @(negedge clk);
        port_evt[port*32 +: 32] = bits;
        @(negedge clk);
        port_evt = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_vec++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 / R2 reset and identity values
        chk("R1 irq at reset", {31'b0, irq}, 32'h0);
        rd(AW'(12'h000), 32'h3,        "R2 capability");
        rd(AW'(12'h00C), 32'hF,        "R2 ports implemented");
        rd(AW'(12'h010), 32'h00010000, "R2 version");
        rd(AW'(12'h004), 32'h80000000, "R1 global control");
        rd(AW'(12'h008), 32'h0,        "R1 global status");
        rd(pa(0, 'h18), 32'h6,         "R1 command");
        rd(pa(0, 'h20), 32'h7F,        "R1 task-file");
        rd(pa(3, 'h24), 32'hFFFFFFFF,  "R1 signature");
        rd(pa(0, 'h38), 32'h0,         "R1 command-issue");
        rd(pa(0, 'h34), 32'h0,         "R1 active");
        rd(pa(0, 'h10), 32'h0,         "R1 int status");
        rd(pa(0, 'h14), 32'h0,         "R1 int enable");

        // R3 global control
        wr(AW'(12'h004), 32'hFFFFFFFF);
        rd(AW'(12'h004), 32'h80000003, "R3 control all ones");
        wr(AW'(12'h004), 32'h0);
        rd(AW'(12'h004), 32'h80000000, "R3 control zero");

        // R5 mask, R12 port isolation
        wr(pa(1, 'h14), 32'hFFFFFFFF);
        rd(pa(1, 'h14), 32'hFDC000FF, "R5 enable mask");
        rd(pa(0, 'h14), 32'h0, "R12 port0 untouched");
        rd(pa(2, 'h14), 32'h0, "R12 port2 untouched");

        // R4 status set / clear / set wins
        evt(1, 32'h5);
        rd(pa(1, 'h10), 32'h5, "R4 event sets");
        wr(pa(1, 'h10), 32'h1);
        rd(pa(1, 'h10), 32'h4, "R4 w1c");
        @(negedge clk);
        port_evt[32 +: 32] = 32'h1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = pa(1, 'h10); bus_wdata = 32'h1;
        @(negedge clk);
        port_evt = '0; bus_valid = 1'b0; bus_write = 1'b0;
        rd(pa(1, 'h10), 32'h5, "R4 set wins over clear");

        // R9 / R10 roll-up and interrupt gating
        idle(1);
        rd(AW'(12'h008), 32'h2, "R9 global bit for port1");
        chk("R10 irq gated by enable", {31'b0, irq}, 32'h0);
        wr(AW'(12'h004), 32'h2);
        chk("R10 irq when enabled", {31'b0, irq}, 32'h1);
        wr(AW'(12'h008), 32'h2);
        rd(AW'(12'h008), 32'h2, "R9 clear ignored while pending");
        wr(pa(1, 'h10), 32'h5);
        rd(pa(1, 'h10), 32'h0, "R4 cleared");
        rd(AW'(12'h008), 32'h2, "R9 sticky after port clear");
        chk("R10 irq still high", {31'b0, irq}, 32'h1);
        wr(AW'(12'h008), 32'h2);
        rd(AW'(12'h008), 32'h0, "R9 cleared");
        chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
        evt(0, 32'h8);
        idle(2);
        rd(AW'(12'h008), 32'h0, "R9 masked event no roll-up");
        chk("R10 irq stays low masked", {31'b0, irq}, 32'h0);

        // R6 write-1-to-set
        wr(pa(2, 'h38), 32'h1);
        wr(pa(2, 'h38), 32'h4);
        wr(pa(2, 'h38), 32'h0);
        rd(pa(2, 'h38), 32'h5, "R6 command-issue or");
        wr(pa(2, 'h34), 32'h10);
        wr(pa(2, 'h34), 32'h20);
        rd(pa(2, 'h34), 32'h30, "R6 active or");

        // R8 command enables and running bits, R7 stop
        wr(pa(2, 'h18), 32'h11);
        chk("R8 list_en", 32'(list_en), 32'h4);
        chk("R8 fis_en", 32'(fis_en), 32'h4);
        rd(pa(2, 'h18), 32'h11, "R8 command readback");
        @(negedge clk);
        list_ack = 4'b0100; fis_ack = 4'b0100;
        rd(pa(2, 'h18), 32'hC011, "R8 running bits follow acks");
        wr(pa(2, 'h18), 32'h10);
        rd(pa(2, 'h38), 32'h0, "R7 stop clears command-issue");
        rd(pa(2, 'h34), 32'h0, "R7 stop clears active");
        rd(pa(2, 'h18), 32'hC010, "R8 write keeps running bits");
        chk("R8 list_en off", 32'(list_en), 32'h0);
        @(negedge clk);
        list_ack = '0; fis_ack = '0;
        wr(pa(2, 'h18), 32'hC010);
        rd(pa(2, 'h18), 32'h10, "R8 running bits not writable");
        wr(pa(2, 'h38), 32'h3);
        wr(pa(2, 'h18), 32'h0);
        rd(pa(2, 'h38), 32'h3, "R7 no clear without falling start");

        // R11 unimplemented and read-only
        wr(pa(4, 'h14), 32'hFFFFFFFF);
        rd(pa(4, 'h14), 32'h0, "R11 unimplemented port read");
        rd(pa(0, 'h14), 32'h0, "R11 no alias into port0");
        rd(pa(3, 'h14), 32'h0, "R11 no alias into port3");
        wr(pa(0, 'h3C), 32'hFFFFFFFF);
        rd(pa(0, 'h3C), 32'h0, "R11 unused port offset");
        rd(AW'(12'h014), 32'h0, "R11 unused global offset");
        wr(pa(0, 'h20), 32'h0);
        rd(pa(0, 'h20), 32'h7F, "R11 task-file read-only");
        wr(AW'(12'h00C), 32'h0);
        rd(AW'(12'h00C), 32'hF, "R11 implemented read-only");

        idle(3);
        chk("R13 all reads returned", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule